// File: doc/BRIEF.md
# Phase-Accumulator Variable Frequency Generator

This block derives a slower square wave from the reference clock. A 16-bit control word gives a step size W. While the run input is high, W is added to a 16-bit phase accumulator on every reference cycle. The top bit of the accumulator is the output, so the output frequency is W / 65536 times the reference frequency. A one-cycle strobe marks each rising edge of that output, so downstream counters can use it as a clock enable.

Software loads the control word one byte at a time: first the upper byte, then the lower byte. The upper byte only waits in a holding register. The lower-byte write forms the full word and marks it pending. While the generator runs, the pending word reaches the accumulator only at a wrap. So the step never mixes two halves, and no phase cycle is cut short. When the generator is stopped, or the current step is zero, the pending word takes over at the next clock edge. A word with its top bit set is used as its 16-bit two's complement. Power-of-two words therefore give an exact half-high, half-low output.

Top module: `vfreq_gen`

## Requirements
- R1: After reset the step word is 0, and `vclk_out` and `tick` are low. They stay low even when `run` is driven high before any word is loaded.
- R2: The step W equals the loaded word when bit 15 of the word is 0. When bit 15 is 1, W is (65536 − word), for example 0xC000 gives 0x4000 and 0xFFFF gives 1.
- R3: With `run` held high, after k rising clock edges `vclk_out` equals bit 15 of (k·W mod 65536). The accumulator starts from zero.
- R4: When `run` is sampled low at a clock edge, the accumulator is cleared to zero, so `vclk_out` is low after that edge.
- R5: `tick` is high for exactly one cycle each time `vclk_out` goes from 0 to 1. `tick` is never high while `vclk_out` is low, and it is never high on two cycles in a row. Over the first N cycles after run rises, there are ⌊(N·W + 32768)/65536⌋ ticks.
- R6: A write to the upper byte (`wr_hi`) alone does not change the step in use.
- R7: While running with a nonzero step, a lower-byte write (`wr_lo`) builds the word {held upper byte, `wr_data`}. This word becomes the step on the clock edge where the accumulator wraps past 65535, and not before. When `run` is low or the step is zero, the word takes effect on the edge after the write.
- R8: A power-of-two word W = 2^p (1 ≤ W ≤ 32768) makes `vclk_out` high for exactly half of each 65536/W-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables accumulation; low clears the accumulator |
| wr_hi | input | 1 | Captures `wr_data` as the upper byte of the word |
| wr_lo | input | 1 | Captures `wr_data` as the lower byte and queues the full word |
| wr_data | input | 8 | Byte being written |
| vclk_out | output | 1 | Accumulator MSB, the variable-frequency square wave |
| tick | output | 1 | One-cycle strobe on each rising edge of `vclk_out` |

## Verification
The hardest case to reach from the ports is a word change while the generator runs. Here the lower-byte write must wait for a wrap that may be many cycles away, and the only visible trace is the output phase. The bench runs a step of 0x0100 and writes a new upper byte in mid-period. It then writes the lower byte well before the wrap at cycle 256. From there it compares every output sample with a piecewise phase model. That model uses the old step up to the wrap and the new step after it. An early commit, or a half-written word, shifts the phase and is caught within a few samples.

// File: rtl/vfreq_gen.sv
module vfreq_gen #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              vclk_out,
  output logic              tick
);
  localparam int ACC_W = 2 * BYTE_W;
  localparam int MSB   = ACC_W - 1;

  logic [BYTE_W-1:0] hi_q;
  logic [ACC_W-1:0]  pend_q, word_q, acc_q, step;
  logic              pend_v, msb_d, carry, commit;
  logic [ACC_W-1:0]  sum;

  assign step   = word_q[MSB] ? (~word_q + 1'b1) : word_q;
  assign {carry, sum} = {1'b0, acc_q} + {1'b0, step};
  assign commit = pend_v && (!run || carry || step == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      word_q <= '0;
      acc_q  <= '0;
      msb_d  <= 1'b0;
    end else begin
      if (wr_hi) hi_q <= wr_data;
      if (wr_lo) begin
        pend_q <= {hi_q, wr_data};
        pend_v <= 1'b1;
      end else if (commit) begin
        pend_v <= 1'b0;
      end
      if (commit) word_q <= pend_q;
      acc_q <= run ? sum : '0;
      msb_d <= acc_q[MSB];
    end
  end

  assign vclk_out = acc_q[MSB];
  assign tick     = acc_q[MSB] & ~msb_d;

  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !vclk_out);
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r5_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> vclk_out);
  a_r6_hi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !pend_v) |=> $stable(word_q));
  a_r7_commit_queued: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> $past(pend_v));
  a_r7_wait_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !carry && step != '0 && !wr_lo) |=> $stable(word_q));
endmodule

// File: tb/vfreq_gen_bench.sv
module vfreq_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0] wr_data = '0;
  logic vclk_out, tick;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vfreq_gen u_vfreq_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .vclk_out(vclk_out), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int msb_of(longint v);
    return int'(((v % 65536) >> 15) & 1);
  endfunction

  function automatic longint step_of(int word);
    return (word >= 32768) ? longint'(65536 - word) : longint'(word);
  endfunction

  task automatic load(input int word);
    run = 1'b0;
    wr_hi = 1'b1; wr_data = word[15:8]; cyc(); wr_hi = 1'b0;
    wr_lo = 1'b1; wr_data = word[7:0];  cyc(); wr_lo = 1'b0;
    cyc(); cyc();
  endtask

  task automatic sweep(input int word, input int n);
    longint w = step_of(word);
    int mism = 0, ticks = 0, highs = 0, lonely = 0;
    longint exp_t;
    load(word);
    run = 1'b1;
    for (int k = 1; k <= n; k++) begin
      cyc();
      if (int'(vclk_out) != msb_of(longint'(k) * w)) mism++;
      if (tick) ticks++;
      if (vclk_out) highs++;
      if (tick && !vclk_out) lonely++;
    end
    chk(mism == 0, "R2/R3 phase", mism, 0);
    exp_t = (longint'(n) * w + 32768) / 65536;
    chk(ticks == exp_t && lonely == 0, "R5 tick count", ticks, exp_t);
    if ((w & (w - 1)) == 0 && w >= 16)
      chk(highs == n / 2, "R8 half duty", highs, n / 2);
    run = 1'b0;
    cyc();
    chk(!vclk_out && !tick, "R4 stop clears", vclk_out, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(!vclk_out && !tick, "R1 reset outputs", vclk_out, 0);
    run = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 50; k++) begin
        cyc();
        if (vclk_out || tick) seen++;
      end
      chk(seen == 0, "R1 zero step idle", seen, 0);
    end
    run = 1'b0;
    cyc();

    for (int p = 0; p < 16; p++) sweep(1 << p, 4096);
    sweep(16'h1234, 4096);
    sweep(16'h7FFF, 4096);
    sweep(16'h8001, 4096);
    sweep(16'hC000, 2048);
    sweep(16'hFFFF, 512);
    sweep(16'h0003, 2048);

    // R4: stop with output high
    load(16'h8000);
    run = 1'b1;
    cyc();
    chk(vclk_out == 1'b1, "R3 first step", vclk_out, 1);
    run = 1'b0;
    cyc();
    chk(!vclk_out, "R4 stop while high", vclk_out, 0);

    // R6: upper byte alone while stopped
    wr_hi = 1'b1; wr_data = 8'h40; cyc(); wr_hi = 1'b0;
    cyc();
    run = 1'b1;
    begin
      int mism = 0;
      for (int k = 1; k <= 8; k++) begin
        cyc();
        if (int'(vclk_out) != msb_of(longint'(k) * 32768)) mism++;
      end
      chk(mism == 0, "R6 hi write ignored", mism, 0);
    end
    run = 1'b0;
    cyc();

    // R6/R7: change the word while running
    load(16'h0100);
    run = 1'b1;
    begin
      int mism_a = 0, mism_b = 0;
      for (int k = 1; k <= 400; k++) begin
        if (k == 101) begin wr_hi = 1'b1; wr_data = 8'h02; end
        if (k == 201) begin wr_lo = 1'b1; wr_data = 8'h00; end
        cyc();
        wr_hi = 1'b0; wr_lo = 1'b0;
        if (k <= 256) begin
          if (int'(vclk_out) != msb_of(longint'(k) * 256)) mism_a++;
        end else begin
          if (int'(vclk_out) != msb_of(longint'(k - 256) * 512)) mism_b++;
        end
      end
      chk(mism_a == 0, "R7 old step until wrap", mism_a, 0);
      chk(mism_b == 0, "R7 new step after wrap", mism_b, 0);
    end
    run = 1'b0;
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule